// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block holds the address of the next microinstruction for a microprogrammed control store. The address has two parts: a 6-bit high part W and an 8-bit low part X. The block runs on a four-phase machine cycle. Each phase arrives as a one-clock strobe, and only the T1, T3 and T4 strobes act on state.

At T1 the working address is loaded from one of several sources. The sources are:
- a constant field of the microword, into W;
- a paired W/X field, whose two lowest X bits come from the branch latches;
- the backup copy;
- the console keys, into W;
- a fixed trap address.

At T3 two branch latches capture the branch-condition results. They hold these results for the next load. At T4 a backup copy takes the working address. An indicating copy for console display also takes it at T4, unless a gated data-path check freezes the display.

A machine-check request always wins over a console load. A console load always wins over the microword's source code. The control store, the microword decode and the ALU lie outside the block.

Top module: `mas_sequencer`

## Requirements
- R1: `cur_addr` changes only on a clock edge where `strobe_t1` is high. It is stable across the T2, T3 and T4 phases.
- R2: Source code `src_sel` selects what loads at T1, with W = `cur_addr[13:8]` and X = `cur_addr[7:0]`:
  - 0: hold;
  - 1: `const_w` into W, X kept;
  - 2: `field_w` into W, `field_x[7:2]` into X[7:2], the branch latches into X[1:0];
  - 3: `backup_addr` into W and X;
  - 4: `keys_w` into W, X kept;
  - 5: trap address;
  - 6 and 7: hold.
- R3: Priority at T1 is `mchk_req` first, then `console_req` (keys into W, X kept), then `src_sel`.
- R4: A machine check loads the trap address parameter `TRAP_ADDR` (default 0) into both W and X.
- R5: `backup_addr` takes `cur_addr` on a `strobe_t4` edge and is unchanged on every other edge.
- R6: The two branch latches capture `branch_cond` on a `strobe_t3` edge. A later code-2 load places them in X[1:0].
- R7: `ind_addr` takes `cur_addr` on a `strobe_t4` edge unless `chk_stop` is high and any bit of `chk_flags` is high. The flag bits are: 0 ALU, 1 A-register, 2 B-register, 3 local store. While `chk_stop` is low, no flag freezes the display.
- R8: Synchronous active-high `rst` clears `cur_addr`, `backup_addr`, `ind_addr` and the branch latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_t1 | input | 1 | Phase T1 strobe (working load) |
| strobe_t3 | input | 1 | Phase T3 strobe (branch latch capture) |
| strobe_t4 | input | 1 | Phase T4 strobe (backup and display capture) |
| src_sel | input | 3 | Microword source code |
| mchk_req | input | 1 | Machine-check trap request |
| console_req | input | 1 | Console key load request |
| const_w | input | 6 | Microword constant for W |
| field_w | input | 6 | Paired field, W part |
| field_x | input | 8 | Paired field, X part |
| keys_w | input | 6 | Console address keys for W |
| branch_cond | input | 2 | Branch-condition results |
| chk_flags | input | 4 | Data-path check flags |
| chk_stop | input | 1 | Check-stop switch |
| cur_addr | output | 14 | Working address {W,X} |
| backup_addr | output | 14 | Backup address |
| ind_addr | output | 14 | Indicating (display) address |

## Verification
Several internal faults would show at the ports:
- A wrong source decode or a broken priority shows on `cur_addr` at the first T1 after the faulty request.
- A stale or mis-timed branch latch shows in X[1:0] after the next code-2 load, one machine cycle after the branch results were presented.
- A backup or display register that loads in the wrong phase differs from its expected value at the next T1 or T4 sample.
- A freeze gate that ignores a flag or the switch shows on `ind_addr` right after that cycle's T4.

// File: rtl/mas_pkg.sv
package mas_pkg;
    parameter int W_W   = 6;
    parameter int X_W   = 8;
    parameter int BR_W  = 2;
    parameter int CHK_N = 4;
    parameter int A_W   = W_W + X_W;

    typedef enum logic [2:0] {
        SRC_HOLD     = 3'd0,
        SRC_CONST_W  = 3'd1,
        SRC_FIELD_WX = 3'd2,
        SRC_BACKUP   = 3'd3,
        SRC_KEYS_W   = 3'd4,
        SRC_TRAP     = 3'd5
    } src_e;

    typedef struct packed {
        logic [W_W-1:0] w;
        logic [X_W-1:0] x;
    } addr_t;

    // Machine check beats console, console beats the microword code.
    function automatic src_e resolve_src(input logic mchk, input logic con,
                                         input logic [2:0] sel);
        if (mchk) return SRC_TRAP;
        if (con) return SRC_KEYS_W;
        if (sel > 3'd5) return SRC_HOLD;
        return src_e'(sel);
    endfunction

    function automatic logic check_freeze(input logic [CHK_N-1:0] flags,
                                          input logic stop);
        return stop & (|flags);
    endfunction
endpackage

// File: rtl/mas_src_select.sv
module mas_src_select
    import mas_pkg::*;
#(
    parameter logic [A_W-1:0] TRAP_ADDR = '0
) (
    input  src_e            src_i,
    input  addr_t           cur_i,
    input  addr_t           bk_i,
    input  logic [BR_W-1:0] brl_i,
    input  logic [W_W-1:0]  const_w_i,
    input  logic [W_W-1:0]  field_w_i,
    input  logic [X_W-1:0]  field_x_i,
    input  logic [W_W-1:0]  keys_w_i,
    output addr_t           nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        case (src_i)
            SRC_CONST_W:  nxt_o.w = const_w_i;
            SRC_FIELD_WX: begin
                nxt_o.w = field_w_i;
                nxt_o.x = {field_x_i[X_W-1:BR_W], brl_i};
            end
            SRC_BACKUP:   nxt_o = bk_i;
            SRC_KEYS_W:   nxt_o.w = keys_w_i;
            SRC_TRAP:     nxt_o = TRAP_ADDR;
            default:      nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/mas_branch_latch.sv
module mas_branch_latch #(
    parameter int BR_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic [BR_W-1:0] d_i,
    output logic [BR_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else if (en_i) q_o <= d_i;
    end

    // R6: latches move only on the T3 strobe
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(q_o));
    a_r6_latch_take: assert property (@(posedge clk) disable iff (rst)
        en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/mas_copy_reg.sv
module mas_copy_reg #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else if (en_i) q_o <= d_i;
    end
endmodule

// File: rtl/mas_sequencer.sv
module mas_sequencer
    import mas_pkg::*;
#(
    parameter logic [A_W-1:0] TRAP_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_t1,
    input  logic             strobe_t3,
    input  logic             strobe_t4,
    input  logic [2:0]       src_sel,
    input  logic             mchk_req,
    input  logic             console_req,
    input  logic [W_W-1:0]   const_w,
    input  logic [W_W-1:0]   field_w,
    input  logic [X_W-1:0]   field_x,
    input  logic [W_W-1:0]   keys_w,
    input  logic [BR_W-1:0]  branch_cond,
    input  logic [CHK_N-1:0] chk_flags,
    input  logic             chk_stop,
    output logic [A_W-1:0]   cur_addr,
    output logic [A_W-1:0]   backup_addr,
    output logic [A_W-1:0]   ind_addr
);
    localparam int N_SHADOW = 2;   // 0: backup, 1: indicating

    addr_t           cur_q, nxt;
    logic [A_W-1:0]  cur_vec;
    logic [A_W-1:0]  shadow_q [N_SHADOW];
    logic [N_SHADOW-1:0] shadow_en;
    logic [BR_W-1:0] brl_q;
    src_e            src;
    logic            frozen;

    assign src    = resolve_src(mchk_req, console_req, src_sel);
    assign frozen = check_freeze(chk_flags, chk_stop);

    mas_src_select #(.TRAP_ADDR(TRAP_ADDR)) u_select (
        .src_i     (src),
        .cur_i     (cur_q),
        .bk_i      (addr_t'(shadow_q[0])),
        .brl_i     (brl_q),
        .const_w_i (const_w),
        .field_w_i (field_w),
        .field_x_i (field_x),
        .keys_w_i  (keys_w),
        .nxt_o     (nxt)
    );

    mas_branch_latch #(.BR_W(BR_W)) u_branch (
        .clk  (clk),
        .rst  (rst),
        .en_i (strobe_t3),
        .d_i  (branch_cond),
        .q_o  (brl_q)
    );

    mas_copy_reg #(.WIDTH(A_W)) u_work (
        .clk  (clk),
        .rst  (rst),
        .en_i (strobe_t1),
        .d_i  (nxt),
        .q_o  (cur_vec)
    );
    assign cur_q = addr_t'(cur_vec);

    assign shadow_en[0] = strobe_t4;
    assign shadow_en[1] = strobe_t4 & ~frozen;

    for (genvar g = 0; g < N_SHADOW; g++) begin : g_shadow
        mas_copy_reg #(.WIDTH(A_W)) u_copy (
            .clk  (clk),
            .rst  (rst),
            .en_i (shadow_en[g]),
            .d_i  (cur_vec),
            .q_o  (shadow_q[g])
        );
    end

    assign cur_addr    = cur_vec;
    assign backup_addr = shadow_q[0];
    assign ind_addr    = shadow_q[1];

    // R1: working address moves only at T1
    a_r1_only_t1: assert property (@(posedge clk) disable iff (rst)
        !strobe_t1 |=> $stable(cur_addr));
    // R3: console load wins over the microword code
    a_r3_console_wins: assert property (@(posedge clk) disable iff (rst)
        (strobe_t1 && !mchk_req && console_req) |=>
            cur_addr[A_W-1:X_W] == $past(keys_w));
    // R4: machine check forces the trap address
    a_r4_trap: assert property (@(posedge clk) disable iff (rst)
        (strobe_t1 && mchk_req) |=> cur_addr == TRAP_ADDR);
    // R5: backup captures the working address at T4 only
    a_r5_backup_take: assert property (@(posedge clk) disable iff (rst)
        strobe_t4 |=> backup_addr == $past(cur_addr));
    a_r5_backup_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe_t4 |=> $stable(backup_addr));
    // R7: display freezes on a gated check
    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        (strobe_t4 && chk_stop && (|chk_flags)) |=> $stable(ind_addr));
    a_r7_update: assert property (@(posedge clk) disable iff (rst)
        (strobe_t4 && !(chk_stop && (|chk_flags))) |=> ind_addr == $past(cur_addr));
endmodule

// File: tb/test_mas_sequencer.sv
module test_mas_sequencer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC = 12;

    typedef struct packed {
        logic        mchk;
        logic        con;
        logic [2:0]  sel;
        logic [5:0]  cw;
        logic [5:0]  fw;
        logic [5:0]  keys;
        logic [7:0]  fx;
        logic [1:0]  br;
        logic [3:0]  chk;
        logic        cstop;
        logic [13:0] exp_cur;
    } vec_t;

    // mchk con sel cw fw keys fx br chk cstop expected cur
    localparam vec_t VEC [N_VEC] = '{
        '{1'b0, 1'b0, 3'd1, 6'h2A, 6'h00, 6'h00, 8'h00, 2'b10, 4'b0000, 1'b0, 14'h2A00}, // R2 code 1
        '{1'b0, 1'b0, 3'd2, 6'h00, 6'h15, 6'h00, 8'hC4, 2'b01, 4'b0000, 1'b0, 14'h15C6}, // R2 R6 code 2
        '{1'b0, 1'b0, 3'd0, 6'h3F, 6'h3F, 6'h3F, 8'hFF, 2'b11, 4'b0000, 1'b0, 14'h15C6}, // R2 hold
        '{1'b0, 1'b0, 3'd4, 6'h00, 6'h00, 6'h3F, 8'h00, 2'b00, 4'b0000, 1'b0, 14'h3FC6}, // R2 keys
        '{1'b0, 1'b0, 3'd1, 6'h01, 6'h00, 6'h00, 8'h00, 2'b01, 4'b0000, 1'b0, 14'h01C6}, // R2 code 1
        '{1'b0, 1'b0, 3'd2, 6'h00, 6'h22, 6'h00, 8'hFF, 2'b11, 4'b0000, 1'b0, 14'h22FD}, // R6 latch 01
        '{1'b0, 1'b0, 3'd1, 6'h0A, 6'h00, 6'h00, 8'h00, 2'b00, 4'b0001, 1'b1, 14'h0AFD}, // R7 freeze
        '{1'b0, 1'b0, 3'd5, 6'h00, 6'h00, 6'h00, 8'h00, 2'b00, 4'b0100, 1'b0, 14'h0000}, // R2 trap, R7 switch off
        '{1'b0, 1'b1, 3'd1, 6'h03, 6'h00, 6'h2C, 8'h00, 2'b00, 4'b0000, 1'b0, 14'h2C00}, // R3 console
        '{1'b1, 1'b1, 3'd2, 6'h00, 6'h15, 6'h11, 8'hAA, 2'b00, 4'b1000, 1'b1, 14'h0000}, // R3 R4 mchk
        '{1'b0, 1'b0, 3'd3, 6'h3F, 6'h00, 6'h00, 8'h00, 2'b00, 4'b0000, 1'b0, 14'h0000}, // R2 backup
        '{1'b0, 1'b0, 3'd6, 6'h3F, 6'h3F, 6'h3F, 8'hFF, 2'b00, 4'b0000, 1'b0, 14'h0000}  // R2 code 6 holds
    };

    logic clk = 1'b0;
    logic rst, strobe_t1, strobe_t3, strobe_t4, mchk_req, console_req, chk_stop;
    logic [2:0]  src_sel;
    logic [5:0]  const_w, field_w, keys_w;
    logic [7:0]  field_x;
    logic [1:0]  branch_cond;
    logic [3:0]  chk_flags;
    logic [13:0] cur_addr, backup_addr, ind_addr;

    int checks = 0;
    int failures = 0;
    logic [13:0] m_bk = '0, m_ind = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mas_sequencer i_mas_sequencer (
        .clk, .rst, .strobe_t1, .strobe_t3, .strobe_t4, .src_sel, .mchk_req,
        .console_req, .const_w, .field_w, .field_x, .keys_w, .branch_cond,
        .chk_flags, .chk_stop, .cur_addr, .backup_addr, .ind_addr
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic machine_cycle(input vec_t v);
        logic [13:0] at_t1;
        mchk_req = v.mchk; console_req = v.con; src_sel = v.sel;
        const_w = v.cw; field_w = v.fw; keys_w = v.keys; field_x = v.fx;
        branch_cond = v.br; chk_flags = v.chk; chk_stop = v.cstop;
        at_t1 = '0;
        for (int p = 0; p < 4; p++) begin
            strobe_t1 = (p == 0); strobe_t3 = (p == 2); strobe_t4 = (p == 3);
            @(posedge clk);
            @(negedge clk);
            if (p == 0) begin
                at_t1 = cur_addr;
                check("R1 R2 R3 R4 cur after T1", cur_addr, v.exp_cur);
                check("R5 backup before T4", backup_addr, m_bk);
            end else begin
                check("R1 cur stable after T1", cur_addr, at_t1);
            end
        end
        strobe_t1 = 0; strobe_t3 = 0; strobe_t4 = 0;
        m_bk = v.exp_cur;
        if (!(v.cstop && (|v.chk))) m_ind = v.exp_cur;
        check("R5 backup after T4", backup_addr, m_bk);
        check("R7 ind after T4", ind_addr, m_ind);
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_bk = '0; m_ind = '0;
    endtask

    initial begin
        rst = 1; strobe_t1 = 0; strobe_t3 = 0; strobe_t4 = 0;
        mchk_req = 0; console_req = 0; src_sel = 0; const_w = 0; field_w = 0;
        keys_w = 0; field_x = 0; branch_cond = 0; chk_flags = 0; chk_stop = 0;
        @(negedge clk);
        do_reset();
        check("R8 cur reset", cur_addr, 14'h0);
        check("R8 backup reset", backup_addr, 14'h0);
        check("R8 ind reset", ind_addr, 14'h0);

        for (int i = 0; i < N_VEC; i++) machine_cycle(VEC[i]);

        // R7: each check flag alone freezes the display when the switch is on
        machine_cycle('{1'b0, 1'b0, 3'd1, 6'h05, 6'h00, 6'h00, 8'h00, 2'b00, 4'b0000, 1'b0, 14'h0500});
        for (int b = 0; b < 4; b++) begin
            vec_t v;
            v = '{1'b0, 1'b0, 3'd1, 6'(b + 8), 6'h00, 6'h00, 8'h00, 2'b00, 4'(1 << b), 1'b1,
                  {6'(b + 8), 8'h00}};
            machine_cycle(v);
            check("R7 frozen by single flag", ind_addr, 14'h0500);
        end

        // R8: mid-run reset clears the branch latches too
        machine_cycle('{1'b0, 1'b0, 3'd2, 6'h00, 6'h30, 6'h00, 8'h80, 2'b11, 4'b0000, 1'b0, 14'h3080});
        do_reset();
        check("R8 cur mid reset", cur_addr, 14'h0);
        check("R8 backup mid reset", backup_addr, 14'h0);
        check("R8 ind mid reset", ind_addr, 14'h0);
        machine_cycle('{1'b0, 1'b0, 3'd2, 6'h00, 6'h0F, 6'h00, 8'h40, 2'b10, 4'b0000, 1'b0, 14'h0F40}); // R6 R8 latch cleared
        machine_cycle('{1'b0, 1'b0, 3'd7, 6'h3F, 6'h3F, 6'h3F, 8'hFF, 2'b01, 4'b0000, 1'b0, 14'h0F40}); // R2 code 7 holds
        machine_cycle('{1'b0, 1'b0, 3'd2, 6'h00, 6'h0F, 6'h00, 8'h40, 2'b00, 4'b0000, 1'b0, 14'h0F41}); // R6 latch from code-7 cycle

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule